// File: doc/BRIEF.md
# Output Slot Watermark Verifier

This block sits next to a suspect filter instance and checks whether that instance carries a hidden ownership mark in its idle output cycles. It supplies the filter with pseudo-random input samples. After each sample is accepted it watches the filter's output for a fixed number of cycles. In a small set of scheduled cycles, where the filter's data-valid flag should be low, it compares the observed output against a secret arithmetic relation. That relation is built from the recent samples and a private coefficient set.

The schedule is a short list of (phase offset, relation id) pairs fixed at elaboration. A run starts with a `start` pulse and covers `num_periods` sample periods. At the end of the run the block reports saturating match and mismatch counts, pulses `done` for one cycle, and raises `pass` when no scheduled slot disagreed.

The stimulus side is a valid/ready source. `stim_valid` stays high and `stim_data` stays stable until the filter raises `stim_ready`, and the filter may stall for any number of cycles. The observed side is passive: the block only samples `obs_valid` and `obs_data` and never pushes back on the filter.

Top module: `wm_slot_verifier`

## Requirements
- R1: While `stim_valid` is high and `stim_ready` is low, `stim_valid` stays high and `stim_data` holds its value on the next cycle. A sample is accepted on a clock edge where both are high.
- R2: The stimulus comes from a 16-bit shift register that is reloaded with the nonzero `SEED` when a run starts, and it advances once per accepted sample. One step shifts the word left by one bit and fills bit 0 with the XOR of bits 15, 13, 12 and 10. The first sample of a run equals `SEED`.
- R3: A run is made of `num_periods` periods, and `num_periods` is latched at start. Each period offers one sample and then watches for `PERIOD` cycles after its acceptance. The next sample is offered in the cycle after the watch window ends. `done` rises on the edge `PERIOD` cycles after the last acceptance, and `stim_valid` is low while `done` is high. A `start` pulse while a run is busy is ignored.
- R4: For a schedule entry with offset `o`, the comparison happens on the clock edge `o+1` cycles after the acceptance edge. Output cycles with no schedule entry are never compared, whatever `obs_valid` and `obs_data` show.
- R5: Let x0 be the sample accepted in the current period, x1 the one before it, and so on back to x7. The delay line is all zero at run start. Let h0..h7 be the 16-bit fields of `COEF`, with h0 in the lowest bits. The relations are unsigned: id 0 = x2*h5, id 1 = x0*h7 + x1*h6, id 2 = x6*h1 + x7*h0, and id 3 = x2*h5.
- R6: A scheduled slot counts as a match only if `obs_valid` is low and `obs_data` equals its relation value. Otherwise it counts as a mismatch, and that includes `obs_valid` high with correct data. When two entries share an offset, the lower-indexed entry decides.
- R7: `match_cnt` and `mis_cnt` are cleared at run start and saturate at all ones instead of wrapping.
- R8: `done` is high for exactly one cycle per run. At that point `pass` is 1 if and only if the run saw no mismatch, and `pass` holds until the next run starts. A run with `num_periods` = 0 raises `done` the cycle after start, with `pass` = 1 and both counts at zero.
- R9: `rst_n` is an asynchronous, active-low reset. While it is low, and after its release, `stim_valid`, `done`, `pass` and both counts are zero. Output activity seen during reset is counted neither as a match nor as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| num_periods | input | NP_W | Periods in the run, latched at start |
| stim_valid | output | 1 | Sample offered to the filter |
| stim_ready | input | 1 | Filter accepts the offered sample |
| stim_data | output | 16 | Pseudo-random sample |
| obs_valid | input | 1 | Filter's data-valid flag |
| obs_data | input | OUT_W | Filter's output word |
| match_cnt | output | CNT_W | Scheduled slots that agreed |
| mis_cnt | output | CNT_W | Scheduled slots that disagreed |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run finished with zero mismatches |

## Verification
The bench holds a model of the suspect filter. That model tracks the accepted samples, and in the cycle after an acceptance it starts its own phase count, so the word it shows in phase `o` sits on the port just before the edge `o+1` cycles after acceptance, which is the edge where the verifier compares. Each accepted `stim_data` is compared against the bench's own shift-register model at the edge of the handshake. A stalled offer is checked one cycle later for held data. `done` is expected on the edge exactly `PERIOD` cycles after the last acceptance, and it must be low again one cycle later. The counts and `pass` are read in the `done` cycle and compared against the expected item that the driver queued when it launched the run.

// File: rtl/wm_pkg.sv
package wm_pkg;

  localparam int SMP_W = 16;
  localparam int TAPS  = 8;
  localparam int NREL  = 4;
  localparam int REL_W = $clog2(NREL);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WATCH = 2'd2
  } vstate_e;

  // one step of the stimulus generator, x^16+x^14+x^13+x^11+1
  function automatic logic [SMP_W-1:0] lfsr_step(input logic [SMP_W-1:0] s);
    return {s[SMP_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/wm_lfsr.sv
module wm_lfsr
  import wm_pkg::*;
#(
  parameter logic [SMP_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [SMP_W-1:0] state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (load) state <= SEED;
    else if (step) state <= lfsr_step(state);
  end

endmodule

// File: rtl/wm_tapline.sv
module wm_tapline #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  shift,
  input  logic [W-1:0]          din,
  output logic [DEPTH-1:0][W-1:0] taps
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     taps[i] <= '0;
        else if (clr)   taps[i] <= '0;
        else if (shift) taps[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     taps[i] <= '0;
        else if (clr)   taps[i] <= '0;
        else if (shift) taps[i] <= taps[i-1];
      end
    end
  end

endmodule

// File: rtl/wm_relation.sv
module wm_relation
  import wm_pkg::*;
#(
  parameter int               CW   = 16,
  parameter int               OW   = SMP_W + CW + 1,
  parameter logic [8*CW-1:0]  COEF = '0
) (
  input  logic [TAPS-1:0][SMP_W-1:0] taps,
  input  logic [REL_W-1:0]           rel,
  output logic [OW-1:0]              value
);

  localparam logic [CW-1:0] H0 = COEF[0*CW +: CW];
  localparam logic [CW-1:0] H1 = COEF[1*CW +: CW];
  localparam logic [CW-1:0] H5 = COEF[5*CW +: CW];
  localparam logic [CW-1:0] H6 = COEF[6*CW +: CW];
  localparam logic [CW-1:0] H7 = COEF[7*CW +: CW];

  function automatic logic [OW-1:0] mul(input logic [SMP_W-1:0] x,
                                        input logic [CW-1:0]    h);
    return OW'(x) * OW'(h);
  endfunction

  // middle taps only carry samples towards the oldest positions
  logic unused_mid;
  assign unused_mid = ^{taps[3], taps[4], taps[5]};

  always_comb begin
    unique case (rel)
      2'd0:    value = mul(taps[2], H5);
      2'd1:    value = mul(taps[0], H7) + mul(taps[1], H6);
      2'd2:    value = mul(taps[6], H1) + mul(taps[7], H0);
      default: value = mul(taps[2], H5);
    endcase
  end

endmodule

// File: rtl/wm_tally.sv
module wm_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && (cnt != '1))  cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/wm_slot_verifier.sv
module wm_slot_verifier
  import wm_pkg::*;
#(
  parameter int                     COEF_W   = 16,
  parameter int                     OUT_W    = SMP_W + COEF_W + 1,
  parameter int                     PERIOD   = 8,
  parameter int                     NSLOT    = 4,
  parameter int                     OFS_W    = 8,
  parameter logic [NSLOT*OFS_W-1:0] SLOT_OFS = 32'h06_04_02_01,
  parameter logic [NSLOT*REL_W-1:0] SLOT_REL = 8'b11_10_01_00,
  parameter logic [8*COEF_W-1:0]    COEF     = {16'd61, 16'd513, 16'd7, 16'd40000,
                                                16'd1021, 16'd250, 16'd17, 16'd3},
  parameter logic [SMP_W-1:0]       SEED     = 16'hACE1,
  parameter int                     CNT_W    = 16,
  parameter int                     NP_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NP_W-1:0]  num_periods,
  output logic             stim_valid,
  input  logic             stim_ready,
  output logic [SMP_W-1:0] stim_data,
  input  logic             obs_valid,
  input  logic [OUT_W-1:0] obs_data,
  output logic [CNT_W-1:0] match_cnt,
  output logic [CNT_W-1:0] mis_cnt,
  output logic             done,
  output logic             pass
);

  localparam int            PH_W    = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);

  vstate_e                    state;
  logic [PH_W-1:0]            ph;
  logic [NP_W-1:0]            per_cnt;
  logic [NP_W-1:0]            np_q;
  logic                       go;
  logic                       accept;
  logic                       watching;
  logic [NSLOT-1:0]           slot_hit;
  logic                       any_hit;
  logic [REL_W-1:0]           rel_sel;
  logic [OUT_W-1:0]           ref_val;
  logic                       slot_ok;
  logic                       mat_inc;
  logic                       mis_inc;
  logic [TAPS-1:0][SMP_W-1:0] taps;

  assign go         = (state == ST_IDLE) && start;
  assign accept     = (state == ST_ISSUE) && stim_ready;
  assign watching   = (state == ST_WATCH);
  assign stim_valid = (state == ST_ISSUE);

  // stimulus source and local copy of the sample history
  wm_lfsr #(.SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (go),
    .step  (accept),
    .state (stim_data)
  );

  wm_tapline #(.W(SMP_W), .DEPTH(TAPS)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (go),
    .shift (accept),
    .din   (stim_data),
    .taps  (taps)
  );

  // schedule decode: one comparator per entry
  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    assign slot_hit[j] = watching &&
                         (OFS_W'(ph) == SLOT_OFS[j*OFS_W +: OFS_W]);
  end

  // lowest-indexed entry wins on a shared offset
  always_comb begin
    any_hit = 1'b0;
    rel_sel = '0;
    for (int j = NSLOT - 1; j >= 0; j--) begin
      if (slot_hit[j]) begin
        any_hit = 1'b1;
        rel_sel = SLOT_REL[j*REL_W +: REL_W];
      end
    end
  end

  wm_relation #(.CW(COEF_W), .OW(OUT_W), .COEF(COEF)) u_rel (
    .taps  (taps),
    .rel   (rel_sel),
    .value (ref_val)
  );

  assign slot_ok = !obs_valid && (obs_data == ref_val);
  assign mat_inc = any_hit && slot_ok;
  assign mis_inc = any_hit && !slot_ok;

  wm_tally #(.CNT_W(CNT_W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (go),
    .inc   (mat_inc),
    .cnt   (match_cnt)
  );

  wm_tally #(.CNT_W(CNT_W)) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (go),
    .inc   (mis_inc),
    .cnt   (mis_cnt)
  );

  // run sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ph      <= '0;
      per_cnt <= '0;
      np_q    <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            per_cnt <= '0;
            np_q    <= num_periods;
            if (num_periods == '0) begin
              done <= 1'b1;
              pass <= 1'b1;
            end else begin
              pass  <= 1'b0;
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (stim_ready) begin
            ph    <= '0;
            state <= ST_WATCH;
          end
        end
        ST_WATCH: begin
          ph <= ph + PH_W'(1);
          if (ph == LAST_PH) begin
            per_cnt <= per_cnt + NP_W'(1);
            if (per_cnt == np_q - NP_W'(1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              pass  <= (mis_cnt == '0) && !mis_inc;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wm_slot_verifier_chk.sv
module wm_slot_verifier_chk #(
  parameter int CNT_W = 16,
  parameter int SMP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stim_valid,
  input logic             stim_ready,
  input logic [SMP_W-1:0] stim_data,
  input logic [CNT_W-1:0] match_cnt,
  input logic [CNT_W-1:0] mis_cnt,
  input logic             done,
  input logic             pass
);

  // R1: a stalled offer keeps its sample
  p_stim_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_valid && !stim_ready) |=> (stim_valid && $stable(stim_data)));

  // R3: nothing is offered while the run is reporting its end
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stim_valid);

  // R7: counts never fall within a run
  p_match_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (match_cnt >= $past(match_cnt)));

  // R7: a full mismatch count stays full
  p_mis_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mis_cnt == {CNT_W{1'b1}}) && !start) |=> (mis_cnt == {CNT_W{1'b1}}));

  // R8: end-of-run pulse lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a passing run shows no mismatch
  p_pass_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (mis_cnt == '0));

endmodule

bind wm_slot_verifier wm_slot_verifier_chk #(.CNT_W(CNT_W), .SMP_W(wm_pkg::SMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .stim_valid (stim_valid),
  .stim_ready (stim_ready),
  .stim_data  (stim_data),
  .match_cnt  (match_cnt),
  .mis_cnt    (mis_cnt),
  .done       (done),
  .pass       (pass)
);

// File: tb/tb_wm_slot_verifier.sv
`timescale 1ns/1ps
module tb_wm_slot_verifier;

  localparam int              PERIOD = 8;
  localparam int              CNT_W  = 5;
  localparam int              NP_W   = 16;
  localparam int              CW     = 16;
  localparam int              OW     = 33;
  localparam logic [15:0]     SEED   = 16'hB5A3;
  localparam logic [8*CW-1:0] COEF   = {16'd61, 16'd513, 16'd7, 16'd40000,
                                        16'd1021, 16'd250, 16'd17, 16'd3};
  localparam int              SAT    = (1 << CNT_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [NP_W-1:0] num_periods = '0;
  logic            stim_valid;
  logic            stim_ready = 1'b0;
  logic [15:0]     stim_data;
  logic            obs_valid = 1'b0;
  logic [OW-1:0]   obs_data = '0;
  logic [CNT_W-1:0] match_cnt;
  logic [CNT_W-1:0] mis_cnt;
  logic            done;
  logic            pass;

  always #2 clk = ~clk;

  wm_slot_verifier #(
    .COEF_W (CW),
    .OUT_W  (OW),
    .PERIOD (PERIOD),
    .COEF   (COEF),
    .SEED   (SEED),
    .CNT_W  (CNT_W),
    .NP_W   (NP_W)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .num_periods (num_periods),
    .stim_valid  (stim_valid),
    .stim_ready  (stim_ready),
    .stim_data   (stim_data),
    .obs_valid   (obs_valid),
    .obs_data    (obs_data),
    .match_cnt   (match_cnt),
    .mis_cnt     (mis_cnt),
    .done        (done),
    .pass        (pass)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    int n;
    int mat;
    int mis;
    bit pas;
  } exp_t;
  exp_t sb[$];

  // filter model and monitor state
  int          mph = -1;
  logic [15:0] mtaps [8];
  bit          hs_prev = 0;
  logic [15:0] hs_data;
  int          hs_cnt = 0;
  logic [15:0] mlfsr = SEED;
  bit          stall_prev = 0;
  logic [15:0] stall_data;
  bit          done_prev = 0;
  int          done_seen = 0;
  int          mode = 0;
  bit          arm = 0;

  function automatic logic [15:0] bstep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic longint unsigned hc(input int i);
    return longint'(COEF[i*CW +: CW]);
  endfunction

  // R5 relations, unsigned
  function automatic logic [OW-1:0] relv(input int r);
    longint unsigned v;
    case (r)
      0:       v = longint'(mtaps[2]) * hc(5);
      1:       v = longint'(mtaps[0]) * hc(7) + longint'(mtaps[1]) * hc(6);
      2:       v = longint'(mtaps[6]) * hc(1) + longint'(mtaps[7]) * hc(0);
      default: v = longint'(mtaps[2]) * hc(5);
    endcase
    return OW'(v);
  endfunction

  // schedule: offset 1 -> id 0, 2 -> id 1, 4 -> id 2, 6 -> id 3
  function automatic int rel_of(input int p);
    case (p)
      1: return 0;
      2: return 1;
      4: return 2;
      6: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    #1 stim_ready = ($urandom_range(0, 3) != 0);
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      mph        = -1;
      hs_prev    = 0;
      stall_prev = 0;
      done_prev  = 0;
      obs_valid <= 1'b0;
      obs_data  <= OW'({$urandom(), $urandom()});
    end else begin
      // end of run results
      if (done_prev) chk(!done, "R8", "done width", done, 0);
      if (done) begin
        exp_t e;
        if (sb.size() == 0) begin
          chk(0, "R8", "unexpected done", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(match_cnt == CNT_W'(e.mat), "R4 R5 R7", "match count", match_cnt, e.mat);
          chk(mis_cnt == CNT_W'(e.mis), "R6 R7", "mismatch count", mis_cnt, e.mis);
          chk(pass == e.pas, "R8", "pass", pass, e.pas);
          chk(hs_cnt == e.n, "R3", "samples accepted", hs_cnt, e.n);
          if (e.n > 0) chk(mph == PERIOD - 1, "R3", "done phase", mph, PERIOD - 1);
        end
        done_seen++;
      end
      done_prev = done;

      if (arm) begin
        for (int i = 0; i < 8; i++) mtaps[i] = '0;
        mlfsr  = SEED;
        hs_cnt = 0;
        arm    = 0;
      end

      if (stall_prev)
        chk(stim_valid && (stim_data == stall_data), "R1", "held offer", stim_data, stall_data);

      // advance the filter model by one cycle
      if (hs_prev) begin
        for (int i = 7; i > 0; i--) mtaps[i] = mtaps[i-1];
        mtaps[0] = hs_data;
        mph = 0;
      end else if (mph >= 0) begin
        mph++;
        if (mph >= PERIOD) mph = -1;
      end

      if (mph >= 0 && rel_of(mph) >= 0) begin
        logic [OW-1:0] v;
        v = relv(rel_of(mph));
        if (mode == 1 && mph == 2) v = v ^ OW'(1);
        obs_data  <= v;
        obs_valid <= (mode == 2 && mph == 4);
      end else begin
        obs_data  <= OW'({$urandom(), $urandom()});
        obs_valid <= (mph == 0);
      end

      // handshake on the coming edge
      hs_prev = stim_valid && stim_ready;
      if (hs_prev) begin
        chk(stim_data == mlfsr, "R2", "sample value", stim_data, mlfsr);
        hs_data = stim_data;
        mlfsr   = bstep(mlfsr);
        hs_cnt++;
      end
      stall_prev = stim_valid && !stim_ready;
      stall_data = stim_data;
    end
  end

  task automatic run(input int n, input int md, input bit poke);
    exp_t e;
    int   target;
    int   m;
    int   x;
    m = (md != 0) ? 3 * n : 4 * n;
    x = (md != 0) ? n : 0;
    e.n   = n;
    e.mat = (m > SAT) ? SAT : m;
    e.mis = (x > SAT) ? SAT : x;
    e.pas = (md == 0);
    sb.push_back(e);
    target = done_seen + 1;
    @(posedge clk); #1;
    mode        = md;
    num_periods = NP_W'(n);
    start       = 1'b1;
    arm         = 1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // R3: start while busy must not restart the run
      repeat (12) @(posedge clk);
      #1;
      num_periods = NP_W'(1);
      start       = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (done_seen < target) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R3", "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!stim_valid, "R9", "reset stim_valid", stim_valid, 0);
    chk(!done, "R9", "reset done", done, 0);
    chk(!pass, "R9", "reset pass", pass, 0);
    chk(match_cnt == 0, "R9", "reset match", match_cnt, 0);
    chk(mis_cnt == 0, "R9", "reset mismatch", mis_cnt, 0);

    run(3, 0, 0);   // clean: all scheduled slots agree
    run(2, 1, 0);   // R6 wrong data in one slot per period
    run(2, 2, 0);   // R6 data-valid high in a scheduled slot
    run(0, 0, 0);   // R8 empty run
    run(10, 0, 0);  // R7 match count saturates
    run(40, 1, 0);  // R7 both counts saturate
    run(2, 0, 1);   // R3 start ignored while busy

    // R9: reset in the middle of a run
    @(posedge clk); #1;
    mode        = 0;
    num_periods = NP_W'(5);
    start       = 1'b1;
    arm         = 1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (15) @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(match_cnt == 0 && mis_cnt == 0, "R9", "counts in reset", match_cnt + mis_cnt, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!stim_valid, "R9", "stim_valid after reset", stim_valid, 0);
    chk(!done && !pass, "R9", "done/pass after reset", {done, pass}, 0);
    chk(match_cnt == 0 && mis_cnt == 0, "R9", "counts after reset", match_cnt + mis_cnt, 0);

    run(3, 0, 0);   // R2 reseeded run after reset

    chk(sb.size() == 0, "R8", "pending results", sb.size(), 0);
    summary();
    $finish;
  end

endmodule